// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the target side of a two-wire serial memory interface and its storage array. While a write transaction is in progress it gathers the incoming data bytes into a one-page latch of 32 bytes. A flag per slot records which bytes actually arrived. At the same time it advances the shared word-address counter. During a write, only the counter's low five bits advance, so the page row never changes and the slot index wraps from the last slot back to the first. If a transaction carries more bytes than a page holds, the later bytes overwrite the earlier ones.

A bus STOP ends the transaction. The block then writes the flagged slots into the array, one slot per clock. It also raises a busy flag for a programmable number of clock cycles, which stands for the self-timed programming interval. The target uses this flag to withhold its acknowledge. While busy, the block ignores every input from the target. A START that arrives while bytes are still waiting cancels the write: the bytes are dropped, nothing is committed and no busy period follows.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy_o` is 0, `mem_we_o` is 0 and `cur_addr_o` is 0.
- R2: While idle with no bytes pending, an `addr_load_i` pulse copies `addr_i` into `cur_addr_o` on the next clock.
- R3: Each accepted byte advances only the low PAGE_W bits of `cur_addr_o`, and 31 wraps to 0. The upper bits stay the same, and after the commit the counter holds the last written address plus one, wrapped within the page.
- R4: A STOP with n pending bytes (1 to 32) commits exactly the slots that received data. The block scans slot indices 0 to 31 in ascending order, one per cycle, and slot s is written in the cycle s+1 after the STOP was sampled. Each write goes to address {row, s}. Slots that received no byte are not written.
- R5: When more than 32 bytes arrive, a byte landing on an already filled slot replaces the older one. At most 32 writes result.
- R6: `busy_o` rises in the cycle after the STOP is sampled and stays high for exactly WRITE_CYCLES cycles. WRITE_CYCLES must be at least 32.
- R7: While `busy_o` is high, `start_i`, `stop_i`, `addr_load_i` and `byte_valid_i` have no effect. The address, the commit and the busy length are all unchanged.
- R8: A START while bytes are pending discards them. A later STOP then writes nothing and raises no busy. The address counter keeps its value.
- R9: A STOP with no bytes pending causes no write and no busy period.
- R10: An `addr_load_i` pulse while bytes are pending is ignored.
- R11: Within one cycle, the inputs are taken in this order of priority: `start_i`, then `stop_i`, then `addr_load_i`, then `byte_valid_i`. Only the winning input acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: bus START seen |
| stop_i | input | 1 | One-cycle pulse: bus STOP seen |
| addr_load_i | input | 1 | Load word address from `addr_i` |
| addr_i | input | ADDR_W | Word address from the target |
| byte_valid_i | input | 1 | A data byte of a write has been received |
| byte_i | input | 8 | Received data byte |
| busy_o | output | 1 | Write cycle in progress; the target withholds ACK |
| cur_addr_o | output | ADDR_W | Shared word-address counter |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Every input pulse is taken at one rising edge. The address counter shows the result one cycle later. After a STOP sampled in cycle k, `busy_o` is first high in cycle k+1 and the write for slot s appears in cycle k+1+s. The bench counts cycles and records the cycle number of every array write. It compares these numbers to the expected offsets, and it counts busy cycles against WRITE_CYCLES. All sampling happens on falling edges, half a cycle after the registers change.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 250000,
  localparam int PAGE_BYTES  = 1 << PAGE_W,
  localparam int TIMER_W     = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);

  logic [7:0]            page_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled_q;
  logic [ADDR_W-1:0]     addr_q;
  logic                  pending_q;
  logic                  commit_q;
  logic [PAGE_W-1:0]     scan_q;
  logic [TIMER_W-1:0]    timer_q;

  logic              idle;
  logic              take_start, take_stop, take_load, take_byte;
  logic [PAGE_W-1:0] slot;

  assign busy_o     = (timer_q != '0) | commit_q;
  assign idle       = ~busy_o;
  assign take_start = idle & start_i;
  assign take_stop  = idle & ~start_i & stop_i & pending_q;
  assign take_load  = idle & ~start_i & ~stop_i & addr_load_i & ~pending_q;
  assign take_byte  = idle & ~start_i & ~stop_i & ~addr_load_i & byte_valid_i;
  assign slot       = addr_q[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (take_byte) page_q[slot] <= byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q  <= '0;
      addr_q    <= '0;
      pending_q <= 1'b0;
      commit_q  <= 1'b0;
      scan_q    <= '0;
      timer_q   <= '0;
    end else begin
      if (take_load) addr_q <= addr_i;
      if (take_byte) begin
        filled_q[slot]         <= 1'b1;
        addr_q[PAGE_W-1:0]     <= slot + 1'b1;
        pending_q              <= 1'b1;
      end
      if (take_start) begin
        filled_q  <= '0;
        pending_q <= 1'b0;
      end
      if (take_stop) begin
        pending_q <= 1'b0;
        commit_q  <= 1'b1;
        scan_q    <= '0;
        timer_q   <= TIMER_W'(WRITE_CYCLES);
      end else if (timer_q != '0) begin
        timer_q <= timer_q - 1'b1;
      end
      if (commit_q) begin
        scan_q <= scan_q + 1'b1;
        if (scan_q == PAGE_W'(PAGE_BYTES - 1)) begin
          commit_q <= 1'b0;
          filled_q <= '0;
        end
      end
    end
  end

  assign cur_addr_o  = addr_q;
  assign mem_we_o    = commit_q & filled_q[scan_q];
  assign mem_addr_o  = {addr_q[ADDR_W-1:PAGE_W], scan_q};
  assign mem_wdata_o = page_q[scan_q];

endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     stop_i,
  input logic                     addr_load_i,
  input logic                     byte_valid_i,
  input logic                     busy_o,
  input logic [ADDR_W-1:0]        cur_addr_o,
  input logic                     mem_we_o,
  input logic [ADDR_W-PAGE_W-1:0] mem_row
);

  // R3
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !busy_o && !start_i && !stop_i && !addr_load_i) |=>
      (cur_addr_o[PAGE_W-1:0] == PAGE_W'($past(cur_addr_o[PAGE_W-1:0]) + 1)) &&
      $stable(cur_addr_o[ADDR_W-1:PAGE_W]));

  // R4
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  // R4
  write_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_row == cur_addr_o[ADDR_W-1:PAGE_W]));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cur_addr_o));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> !busy_o);

endmodule

bind page_write_buffer page_write_buffer_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .addr_load_i  (addr_load_i),
  .byte_valid_i (byte_valid_i),
  .busy_o       (busy_o),
  .cur_addr_o   (cur_addr_o),
  .mem_we_o     (mem_we_o),
  .mem_row      (mem_addr_o[ADDR_W-1:PAGE_W])
);

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;
  localparam int AW = 13;
  localparam int PW = 5;
  localparam int WC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, stop_i = 1'b0, addr_load_i = 1'b0, byte_valid_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    byte_i = '0;
  logic          busy_o, mem_we_o;
  logic [AW-1:0] cur_addr_o, mem_addr_o;
  logic [7:0]    mem_wdata_o;

  page_write_buffer #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) u_page_write_buffer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .addr_load_i(addr_load_i), .addr_i(addr_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .busy_o(busy_o), .cur_addr_o(cur_addr_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  int wr_n = 0, busy_total = 0, stop_cyc = 0;
  int wr_addr [128];
  int wr_data [128];
  int wr_cyc  [128];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && mem_we_o && wr_n < 128) begin
      wr_addr[wr_n] = mem_addr_o;
      wr_data[wr_n] = mem_wdata_o;
      wr_cyc[wr_n]  = cyc;
      wr_n = wr_n + 1;
    end
    if (rst_n && busy_o) busy_total = busy_total + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic load_addr(input int a);
    @(negedge clk); addr_load_i = 1'b1; addr_i = AW'(a);
    @(negedge clk); addr_load_i = 1'b0;
  endtask

  task automatic send_byte(input int b);
    @(negedge clk); byte_valid_i = 1'b1; byte_i = 8'(b);
    @(negedge clk); byte_valid_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1; stop_cyc = cyc;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic settle();
    repeat (WC + 10) @(negedge clk);
  endtask

  task automatic t_reset();
    check_eq("R1 busy", busy_o, 0);
    check_eq("R1 we", mem_we_o, 0);
    check_eq("R1 addr", cur_addr_o, 0);
    check_eq("R1 no writes", wr_n, 0);
  endtask

  task automatic t_load();
    load_addr('h0123);
    check_eq("R2 load", cur_addr_o, 'h0123);
  endtask

  task automatic t_partial();
    int w0 = wr_n, b0 = busy_total;
    load_addr('h0A45);
    send_byte('h11); check_eq("R3 step1", cur_addr_o, 'h0A46);
    send_byte('h22); check_eq("R3 step2", cur_addr_o, 'h0A47);
    send_byte('h33); check_eq("R3 step3", cur_addr_o, 'h0A48);
    pulse_stop();
    check_eq("R6 busy rises", busy_o, 1);
    settle();
    check_eq("R4 count", wr_n - w0, 3);
    for (int i = 0; i < 3; i++) begin
      check_eq("R4 addr", wr_addr[w0+i], 'h0A45 + i);
      check_eq("R4 data", wr_data[w0+i], 'h11 * (i + 1));
      check_eq("R4 cycle", wr_cyc[w0+i], stop_cyc + 1 + 5 + i);
    end
    check_eq("R6 busy length", busy_total - b0, WC);
    check_eq("R3 after commit", cur_addr_o, 'h0A48);
  endtask

  task automatic t_wrap();
    int w0 = wr_n;
    int ea[4] = '{'h1F20, 'h1F21, 'h1F3E, 'h1F3F};
    int ed[4] = '{'hB3, 'hB4, 'hB1, 'hB2};
    load_addr('h1F3E);
    send_byte('hB1); send_byte('hB2); send_byte('hB3); send_byte('hB4);
    check_eq("R3 wrap addr", cur_addr_o, 'h1F22);
    pulse_stop(); settle();
    check_eq("R4 wrap count", wr_n - w0, 4);
    for (int i = 0; i < 4; i++) begin
      check_eq("R4 wrap order addr", wr_addr[w0+i], ea[i]);
      check_eq("R4 wrap data", wr_data[w0+i], ed[i]);
    end
  endtask

  task automatic t_overflow();
    int w0 = wr_n;
    load_addr('h0040);
    for (int i = 0; i < 34; i++) send_byte(i + 1);
    pulse_stop(); settle();
    check_eq("R5 count", wr_n - w0, 32);
    for (int k = 0; k < 32; k++) begin
      check_eq("R5 addr", wr_addr[w0+k], 'h0040 + k);
      check_eq("R5 data", wr_data[w0+k], (k < 2) ? 33 + k : k + 1);
    end
    check_eq("R5 cur addr", cur_addr_o, 'h0042);
  endtask

  task automatic t_busy_ignore();
    int w0 = wr_n, b0 = busy_total;
    load_addr('h0100);
    send_byte('hAA);
    pulse_stop();
    load_addr('h0555);
    send_byte('h77);
    pulse_start();
    pulse_stop();
    check_eq("R7 addr held", cur_addr_o, 'h0101);
    settle();
    check_eq("R7 write count", wr_n - w0, 1);
    check_eq("R7 write addr", wr_addr[w0], 'h0100);
    check_eq("R7 write data", wr_data[w0], 'hAA);
    check_eq("R7 busy length", busy_total - b0, WC);
    check_eq("R7 addr after", cur_addr_o, 'h0101);
    b0 = busy_total;
    pulse_stop(); repeat (4) @(negedge clk);
    check_eq("R7 no byte kept", busy_total - b0, 0);
  endtask

  task automatic t_abort();
    int w0 = wr_n, b0 = busy_total;
    load_addr('h0200);
    send_byte('h01); send_byte('h02);
    pulse_start();
    check_eq("R8 no busy on START", busy_o, 0);
    pulse_stop(); settle();
    check_eq("R8 no writes", wr_n - w0, 0);
    check_eq("R8 no busy", busy_total - b0, 0);
    check_eq("R8 addr kept", cur_addr_o, 'h0202);
  endtask

  task automatic t_empty_stop();
    int w0 = wr_n, b0 = busy_total;
    pulse_stop(); repeat (6) @(negedge clk);
    check_eq("R9 no writes", wr_n - w0, 0);
    check_eq("R9 no busy", busy_total - b0, 0);
  endtask

  task automatic t_load_pending();
    int w0 = wr_n;
    load_addr('h0300);
    send_byte('h5A);
    load_addr('h0777);
    check_eq("R10 load ignored", cur_addr_o, 'h0301);
    pulse_stop(); settle();
    check_eq("R10 count", wr_n - w0, 1);
    check_eq("R10 addr", wr_addr[w0], 'h0300);
    check_eq("R10 data", wr_data[w0], 'h5A);
  endtask

  task automatic t_priority();
    int w0 = wr_n, b0 = busy_total;
    load_addr('h0400);
    @(negedge clk); addr_load_i = 1'b1; addr_i = AW'('h0808); byte_valid_i = 1'b1; byte_i = 8'h99;
    @(negedge clk); addr_load_i = 1'b0; byte_valid_i = 1'b0;
    check_eq("R11 load beats byte", cur_addr_o, 'h0808);
    send_byte('h3C);
    @(negedge clk); start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
    check_eq("R11 start beats stop", busy_o, 0);
    pulse_stop(); settle();
    check_eq("R11 no commit", wr_n - w0, 0);
    check_eq("R11 no busy", busy_total - b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_partial();
    t_wrap();
    t_overflow();
    t_busy_ignore();
    t_abort();
    t_empty_stop();
    t_load_pending();
    t_priority();
    finish_run();
  end
endmodule